// File: doc/BRIEF.md
# Tiled 4x4 Unsigned Array Multiplier

This block multiplies two unsigned 4-bit operands and drives their full 8-bit product. It has no clock and no storage, so the product follows the operands within the same cycle. It suits a datapath that needs a small, exact product with no latency.

Each operand is split into a low bit pair and a high bit pair. Four identical 2x2 multiplier tiles form the products of these pairs. Each tile ANDs its bit pairs and sums the results with half adders. A ripple network of half and full adders then shifts the tile results into place and adds them. The tile is a reusable module of its own.

Top module: `tiled_mul4x4`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals `a_op * b_op`. All 256 combinations are covered.
- R2: No carry is lost. The largest case, 15 x 15, gives 225 (8'b1110_0001) exactly on `prod`.
- R3: When either operand is zero, `prod` is zero.
- R4: The 2x2 tile `mul2x2_tile` drives `p` equal to `a * b` for all 16 input pairs. Its bit 0 is `a[0]&b[0]`, and its largest value is 9, reached only when a=3 and b=3.
- R5: The operand halves carry the right weights. The low pair is bits [1:0] and the high pair is bits [3:2]. Cross terms weigh 4 and the high-by-high term weighs 16, so 4 x 4 gives 16, 12 x 12 gives 144 and 3 x 12 gives 36.
- R6: Operands 13 and 11 give 143 (8'b1000_1111).
- R7: When either operand is 1, `prod` equals the other operand.
- R8: The block is combinational. A new operand pair is reflected on `prod` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | 4 | Unsigned multiplier operand |
| b_op | input | 4 | Unsigned multiplicand operand |
| prod | output | 8 | Unsigned product a_op * b_op |

## Verification
The in-RTL checks assume that both operands are settled, two-state values, because they are immediate checks evaluated whenever the logic settles. The bench drives operands only between clock edges and always drives known bits. It samples `prod` one nanosecond later, well before the next edge. The stimulus is an exhaustive sweep, seeded random pairs and directed corners (zero, one, 15, 13 x 11), so every operand value the checks reason about is reached.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int unsigned TILE_W = 2;
  localparam int unsigned OP_W   = 2 * TILE_W;
  localparam int unsigned TP_W   = 2 * TILE_W;
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned MAX_OP = (1 << OP_W) - 1;
  localparam int unsigned MAX_PROD = MAX_OP * MAX_OP;
endpackage

// File: rtl/half_adder.sv
module half_adder (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/full_adder.sv
module full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic s1, c1, c2;
  half_adder ha0_i (.x(x),  .y(y),  .s(s1), .c(c1));
  half_adder ha1_i (.x(s1), .y(ci), .s(s),  .c(c2));
  assign co = c1 | c2;
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   sum
);
  logic [W:0] cy;

  half_adder lsb_i (.x(x[0]), .y(y[0]), .s(sum[0]), .c(cy[1]));
  assign cy[0] = 1'b0;

  generate
    for (genvar k = 1; k < W; k++) begin : g_fa
      full_adder fa_i (.x(x[k]), .y(y[k]), .ci(cy[k]), .s(sum[k]), .co(cy[k+1]));
    end
  endgenerate

  assign sum[W] = cy[W];
endmodule

// File: rtl/mul2x2_tile.sv
module mul2x2_tile (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic pp00, pp10, pp01, pp11;
  logic c_mid;

  assign pp00 = a[0] & b[0];
  assign pp10 = a[1] & b[0];
  assign pp01 = a[0] & b[1];
  assign pp11 = a[1] & b[1];

  assign p[0] = pp00;
  half_adder ha_mid_i (.x(pp10), .y(pp01),  .s(p[1]), .c(c_mid));
  half_adder ha_top_i (.x(pp11), .y(c_mid), .s(p[2]), .c(p[3]));

  always_comb begin
    AST_TILE_LSB: assert (p[0] == (a[0] & b[0])); // R4
    AST_TILE_MAX: assert ((p == 4'd9) == (a == 2'd3 && b == 2'd3)); // R4
    AST_TILE_RANGE: assert (p <= 4'd9); // R4
  end
endmodule

// File: rtl/tiled_mul4x4.sv
module tiled_mul4x4
  import mul_pkg::*;
(
  input  logic [OP_W-1:0]   a_op,
  input  logic [OP_W-1:0]   b_op,
  output logic [PROD_W-1:0] prod
);
  localparam int unsigned UP_W = PROD_W - TILE_W;

  logic [TILE_W-1:0] a_half [2];
  logic [TILE_W-1:0] b_half [2];
  logic [TP_W-1:0]   tile_p [2][2];

  assign a_half[0] = a_op[TILE_W-1:0];
  assign a_half[1] = a_op[OP_W-1:TILE_W];
  assign b_half[0] = b_op[TILE_W-1:0];
  assign b_half[1] = b_op[OP_W-1:TILE_W];

  generate
    for (genvar i = 0; i < 2; i++) begin : g_arow
      for (genvar j = 0; j < 2; j++) begin : g_bcol
        mul2x2_tile tile_i (.a(a_half[i]), .b(b_half[j]), .p(tile_p[i][j]));
      end
    end
  endgenerate

  logic [TP_W:0] cross_sum;
  ripple_add #(.W(TP_W)) cross_add_i (
    .x  (tile_p[1][0]),
    .y  (tile_p[0][1]),
    .sum(cross_sum)
  );

  logic [UP_W-1:0] outer_term;
  logic [UP_W-1:0] cross_ext;
  logic [UP_W:0]   upper_sum;

  assign outer_term = {tile_p[1][1], tile_p[0][0][TP_W-1:TILE_W]};
  assign cross_ext  = {{(UP_W-TP_W-1){1'b0}}, cross_sum};

  ripple_add #(.W(UP_W)) upper_add_i (
    .x  (outer_term),
    .y  (cross_ext),
    .sum(upper_sum)
  );

  assign prod = {upper_sum[UP_W-1:0], tile_p[0][0][TILE_W-1:0]};

  always_comb begin
    AST_NO_OVERFLOW: assert (upper_sum[UP_W] == 1'b0); // R2
    AST_PROD_RANGE: assert (32'(prod) <= MAX_PROD); // R2
    AST_ZERO_OPERAND: assert (!(a_op == '0 || b_op == '0) || prod == '0); // R3
    AST_UNIT_A: assert (a_op != OP_W'(1) || prod == PROD_W'(b_op)); // R7
    AST_UNIT_B: assert (b_op != OP_W'(1) || prod == PROD_W'(a_op)); // R7
  end
endmodule

// File: tb/tiled_mul4x4_tb_top.sv
module tiled_mul4x4_tb_top;
  logic clk;
  logic rst_n;
  logic [3:0] a_op, b_op;
  logic [7:0] prod;
  logic [1:0] ta, tb;
  logic [3:0] tp;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  tiled_mul4x4 dut_i (.a_op(a_op), .b_op(b_op), .prod(prod));
  mul2x2_tile  tile_i (.a(ta), .b(tb), .p(tp));

  function automatic logic [7:0] ref_mul(input logic [3:0] x, input logic [3:0] y);
    int acc = 0;
    for (int k = 0; k < 4; k++) if (y[k]) acc += int'(x) << k;
    return acc[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] x, input logic [3:0] y);
    @(negedge clk);
    a_op = x; b_op = y;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] first;
    rst_n = 1'b0; a_op = 4'd0; b_op = 4'd0; ta = 2'd0; tb = 2'd0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R3 initial zero", prod, 8'd0);

    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++) begin
        @(negedge clk);
        ta = 2'(x); tb = 2'(y);
        #1;
        check("R4 tile", {4'd0, tp}, 8'(x * y));
      end

    apply(4'd13, 4'd11); check("R6 13x11", prod, 8'd143);
    apply(4'd15, 4'd15); check("R2 max", prod, 8'd225);
    apply(4'd4, 4'd4);   check("R5 cross weight", prod, 8'd16);
    apply(4'd12, 4'd12); check("R5 high weight", prod, 8'd144);
    apply(4'd3, 4'd12);  check("R5 mixed", prod, 8'd36);
    apply(4'd0, 4'd15);  check("R3 zero a", prod, 8'd0);
    apply(4'd9, 4'd0);   check("R3 zero b", prod, 8'd0);
    apply(4'd1, 4'd14);  check("R7 unit a", prod, 8'd14);
    apply(4'd11, 4'd1);  check("R7 unit b", prod, 8'd11);

    // R8: change operands between edges, product follows with no clock edge
    @(posedge clk); #1;
    a_op = 4'd7; b_op = 4'd6; #1;
    first = prod;
    check("R8 no clock a", first, 8'd42);
    a_op = 4'd5; #1;
    check("R8 no clock b", prod, 8'd30);

    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        apply(4'(x), 4'(y));
        check("R1 exhaustive", prod, ref_mul(4'(x), 4'(y)));
      end

    void'($urandom(32'd1234));
    for (int n = 0; n < 200; n++) begin
      logic [3:0] rx, ry;
      rx = 4'($urandom()); ry = 4'($urandom());
      apply(rx, ry);
      check("R1 random", prod, ref_mul(rx, ry));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule